// File: doc/BRIEF.md
# Sequential Integer Divider

This block computes quotients and remainders of two integer operands, signed or unsigned, one operation at a time. It uses a radix-2 restoring iteration that retires one quotient bit per clock. The caller raises `start_i` for one cycle with the operands and controls. The unit then keeps `busy_o` high while it works and pulses `done_o` for one cycle when `result_o` carries the answer. The result stays on `result_o` until a later operation writes a new one.

Operations are either full width (64-bit register mode) or narrow. An operation is narrow when the word flag is set or the register mode is 32-bit. A narrow operation reads only the low 32 bits of each operand and returns a 32-bit value sign-extended to 64 bits. A zero divisor and the signed overflow case (most negative value divided by −1) are found in the setup cycle. They bypass the iteration and return fixed values, and no exception is raised.

The controller is a five-state machine:
- ST_IDLE waits for work.
- ST_PREP conditions the operands and detects the special cases.
- ST_ITER runs one quotient bit per cycle.
- ST_FIXUP applies the signs and sign-extends.
- ST_FINISH presents `done_o`.

Its transitions are:
- T_ACCEPT: ST_IDLE→ST_PREP on start.
- T_SHORTCUT: ST_PREP→ST_FINISH for a special case.
- T_BEGIN: ST_PREP→ST_ITER otherwise.
- T_LAST: ST_ITER→ST_FIXUP when the bit count runs out.
- T_COMMIT: ST_FIXUP→ST_FINISH.
- T_CHAIN: ST_FINISH→ST_PREP on a start in the done cycle.
- T_RELEASE: ST_FINISH→ST_IDLE.

Top module: `idiv_seq_unit`

## Requirements
- R1: While reset is asserted and right after it, `busy_o` and `done_o` are 0 and `result_o` is 0.
- R2: `op_i` selects the operation: 2'b00 signed quotient, 2'b01 unsigned quotient, 2'b10 signed remainder, 2'b11 unsigned remainder. Quotients truncate toward zero, and a signed remainder carries the sign of the dividend.
- R3: A quotient with a zero divisor returns all ones on all 64 bits, for both signed and unsigned operations and for both widths.
- R4: A remainder with a zero divisor returns the dividend. For a narrow operation this is the low 32 bits of the dividend, sign-extended.
- R5: A signed quotient of the most negative value by −1 returns the most negative value, and the matching signed remainder returns 0. For a narrow operation the most negative value is 0xFFFFFFFF80000000.
- R6: An operation is narrow when `word_i`=1 or `mode64_i`=0. It ignores operand bits 63:32, and its result is bits 31:0 sign-extended, including for the unsigned operations.
- R7: `done_o` rises exactly N+2 clock edges after the edge that accepted the start, where N is 32 for narrow and 64 for full-width operations. A zero-divisor or overflow case raises `done_o` one edge after acceptance.
- R8: A start raised while `busy_o` is 1 is ignored, and the operation in flight completes with its original operands.
- R9: `done_o` is high for exactly one cycle and never together with `busy_o`. `result_o` changes only on the edge that raises `done_o`.
- R10: A start presented in the cycle where `done_o` is high is accepted, and `busy_o` is 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a new operation |
| op_i | input | 2 | Operation select (see R2) |
| word_i | input | 1 | Word operation: 32-bit with sign-extended result |
| mode64_i | input | 1 | 1 = 64-bit register mode, 0 = 32-bit register mode |
| opa_i | input | 64 | Dividend |
| opb_i | input | 64 | Divisor |
| busy_o | output | 1 | Operation in progress, starts ignored |
| done_o | output | 1 | One-cycle pulse: result valid |
| result_o | output | 64 | Quotient or remainder |

## Verification
The done pulse of one operation and the acceptance of the next start can fall in the same cycle. This happens because the driver presents each new request at the first cycle where `busy_o` is low, which is the done cycle whenever requests are queued back to back. The monitor compares the finishing result against its scoreboard in that same cycle. It then checks, one cycle later, that `done_o` dropped and `result_o` held, while the driver confirms that the chained operation went busy. Latency is measured from each accepting edge, so a chained operation that counted its first cycle wrongly is caught as a latency mismatch.

// File: rtl/idiv_pkg.sv
package idiv_pkg;

    typedef enum logic [1:0] {
        OP_DIV  = 2'b00,
        OP_DIVU = 2'b01,
        OP_REM  = 2'b10,
        OP_REMU = 2'b11
    } idiv_op_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_PREP   = 3'd1,
        ST_ITER   = 3'd2,
        ST_FIXUP  = 3'd3,
        ST_FINISH = 3'd4
    } idiv_state_e;

    typedef struct packed {
        logic is_signed;
        logic want_rem;
        logic narrow;
    } idiv_ctl_t;

    function automatic idiv_ctl_t idiv_decode(input logic [1:0] op,
                                              input logic word,
                                              input logic mode64);
        idiv_ctl_t c;
        c.is_signed = (idiv_op_e'(op) == OP_DIV) || (idiv_op_e'(op) == OP_REM);
        c.want_rem  = (idiv_op_e'(op) == OP_REM) || (idiv_op_e'(op) == OP_REMU);
        c.narrow    = word | ~mode64;
        return c;
    endfunction

endpackage

// File: rtl/idiv_prep.sv
module idiv_prep
    import idiv_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  idiv_ctl_t        ctl_i,
    input  logic [XLEN-1:0]  a_i,
    input  logic [XLEN-1:0]  b_i,
    output logic [XLEN-1:0]  dvd_load_o,
    output logic [XLEN-1:0]  dvsr_o,
    output logic [XLEN-1:0]  fixed_o,
    output logic             neg_q_o,
    output logic             neg_r_o,
    output logic             special_o
);
    localparam int HALF = XLEN / 2;
    localparam logic [XLEN-1:0] WIDE_MIN = {1'b1, {(XLEN-1){1'b0}}};
    localparam logic [HALF-1:0] HALF_MIN = {1'b1, {(HALF-1){1'b0}}};

    logic [XLEN-1:0] ext_a;
    logic [XLEN-1:0] ext_b;
    logic [XLEN-1:0] mag_a;
    logic [XLEN-1:0] mag_b;
    logic            neg_a;
    logic            neg_b;
    logic            b_zero;
    logic            a_min;
    logic            b_minus1;

    // Extend a narrow operand to the full datapath width
    function automatic logic [XLEN-1:0] widen(input logic [XLEN-1:0] v,
                                              input logic sgn,
                                              input logic nar);
        if (nar) begin
            return {{HALF{sgn & v[HALF-1]}}, v[HALF-1:0]};
        end
        return v;
    endfunction

    always_comb begin
        ext_a    = widen(a_i, ctl_i.is_signed, ctl_i.narrow);
        ext_b    = widen(b_i, ctl_i.is_signed, ctl_i.narrow);
        neg_a    = ctl_i.is_signed & ext_a[XLEN-1];
        neg_b    = ctl_i.is_signed & ext_b[XLEN-1];
        mag_a    = neg_a ? (~ext_a + 1'b1) : ext_a;
        mag_b    = neg_b ? (~ext_b + 1'b1) : ext_b;
        b_zero   = (ext_b == '0);
        b_minus1 = &ext_b;
        a_min    = ctl_i.narrow ? (a_i[HALF-1:0] == HALF_MIN) : (a_i == WIDE_MIN);

        special_o = b_zero | (ctl_i.is_signed & a_min & b_minus1);

        // Fixed results before the final narrow sign extension
        if (b_zero) begin
            fixed_o = ctl_i.want_rem ? a_i : {XLEN{1'b1}};
        end else begin
            fixed_o = ctl_i.want_rem ? '0 : a_i;
        end

        // Narrow dividend sits in the upper half so HALF shifts drain it
        dvd_load_o = ctl_i.narrow ? {mag_a[HALF-1:0], {HALF{1'b0}}} : mag_a;
        dvsr_o     = mag_b;
        neg_q_o    = neg_a ^ neg_b;
        neg_r_o    = neg_a;
    end

endmodule

// File: rtl/idiv_step.sv
module idiv_step #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] part_i,
    input  logic [XLEN-1:0] quo_i,
    input  logic [XLEN-1:0] dvsr_i,
    output logic [XLEN-1:0] part_o,
    output logic [XLEN-1:0] quo_o
);
    logic [XLEN:0] shifted;
    logic [XLEN:0] trial;
    logic          fits;

    always_comb begin
        shifted = {part_i, quo_i[XLEN-1]};
        trial   = shifted - {1'b0, dvsr_i};
        fits    = ~trial[XLEN];
        part_o  = fits ? trial[XLEN-1:0] : shifted[XLEN-1:0];
        quo_o   = {quo_i[XLEN-2:0], fits};
    end

endmodule

// File: rtl/idiv_core.sv
module idiv_core #(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic            step_i,
    input  logic [XLEN-1:0] dvd_i,
    input  logic [XLEN-1:0] dvsr_i,
    output logic [XLEN-1:0] quo_o,
    output logic [XLEN-1:0] rem_o
);
    logic [XLEN-1:0] part_q;
    logic [XLEN-1:0] quo_q;
    logic [XLEN-1:0] dvsr_q;
    logic [XLEN-1:0] part_n;
    logic [XLEN-1:0] quo_n;

    idiv_step #(.XLEN(XLEN)) u_step (
        .part_i (part_q),
        .quo_i  (quo_q),
        .dvsr_i (dvsr_q),
        .part_o (part_n),
        .quo_o  (quo_n)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            part_q <= '0;
            quo_q  <= '0;
            dvsr_q <= '0;
        end else if (load_i) begin
            part_q <= '0;
            quo_q  <= dvd_i;
            dvsr_q <= dvsr_i;
        end else if (step_i) begin
            part_q <= part_n;
            quo_q  <= quo_n;
        end
    end

    assign quo_o = quo_q;
    assign rem_o = part_q;

endmodule

// File: rtl/idiv_fix.sv
module idiv_fix
    import idiv_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  idiv_ctl_t        ctl_i,
    input  logic             use_fixed_i,
    input  logic [XLEN-1:0]  fixed_i,
    input  logic [XLEN-1:0]  quo_i,
    input  logic [XLEN-1:0]  rem_i,
    input  logic             neg_q_i,
    input  logic             neg_r_i,
    output logic [XLEN-1:0]  res_o
);
    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] q_signed;
    logic [XLEN-1:0] r_signed;
    logic [XLEN-1:0] chosen;

    always_comb begin
        q_signed = neg_q_i ? (~quo_i + 1'b1) : quo_i;
        r_signed = neg_r_i ? (~rem_i + 1'b1) : rem_i;
        if (use_fixed_i) begin
            chosen = fixed_i;
        end else begin
            chosen = ctl_i.want_rem ? r_signed : q_signed;
        end
        res_o = ctl_i.narrow ? {{HALF{chosen[HALF-1]}}, chosen[HALF-1:0]} : chosen;
    end

endmodule

// File: rtl/idiv_seq_unit.sv
module idiv_seq_unit
    import idiv_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [1:0]      op_i,
    input  logic            word_i,
    input  logic            mode64_i,
    input  logic [XLEN-1:0] opa_i,
    input  logic [XLEN-1:0] opb_i,
    output logic            busy_o,
    output logic            done_o,
    output logic [XLEN-1:0] result_o
);
    localparam int HALF = XLEN / 2;
    localparam int CW   = $clog2(XLEN + 1);

    idiv_state_e     state_q;
    idiv_state_e     state_d;
    idiv_ctl_t       ctl_q;
    logic [XLEN-1:0] a_q;
    logic [XLEN-1:0] b_q;
    logic [CW-1:0]   cnt_q;
    logic [XLEN-1:0] res_q;
    logic            accept;
    logic            last_bit;

    logic [XLEN-1:0] dvd_load;
    logic [XLEN-1:0] dvsr;
    logic [XLEN-1:0] fixed_val;
    logic            neg_q;
    logic            neg_r;
    logic            special;
    logic [XLEN-1:0] quo_mag;
    logic [XLEN-1:0] rem_mag;
    logic [XLEN-1:0] fix_res;
    logic            core_load;
    logic            core_step;
    logic            write_res;

    assign accept   = start_i && ((state_q == ST_IDLE) || (state_q == ST_FINISH));
    assign last_bit = (cnt_q == CW'(1));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_PREP;                  // T_ACCEPT
            ST_PREP:   state_d = special ? ST_FINISH : ST_ITER;        // T_SHORTCUT / T_BEGIN
            ST_ITER:   if (last_bit) state_d = ST_FIXUP;               // T_LAST
            ST_FIXUP:  state_d = ST_FINISH;                            // T_COMMIT
            ST_FINISH: state_d = accept ? ST_PREP : ST_IDLE;           // T_CHAIN / T_RELEASE
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs decoded from state
    always_comb begin
        busy_o    = (state_q == ST_PREP) || (state_q == ST_ITER) || (state_q == ST_FIXUP);
        done_o    = (state_q == ST_FINISH);
        core_load = (state_q == ST_PREP);
        core_step = (state_q == ST_ITER);
        write_res = ((state_q == ST_PREP) && special) || (state_q == ST_FIXUP);
    end

    // Operand capture on acceptance only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
            a_q   <= '0;
            b_q   <= '0;
        end else if (accept) begin
            ctl_q <= idiv_decode(op_i, word_i, mode64_i);
            a_q   <= opa_i;
            b_q   <= opb_i;
        end
    end

    // Quotient bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_q == ST_PREP) begin
            cnt_q <= ctl_q.narrow ? CW'(HALF) : CW'(XLEN);
        end else if (state_q == ST_ITER) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    // Result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else if (write_res) begin
            res_q <= fix_res;
        end
    end

    assign result_o = res_q;

    idiv_prep #(.XLEN(XLEN)) u_prep (
        .ctl_i      (ctl_q),
        .a_i        (a_q),
        .b_i        (b_q),
        .dvd_load_o (dvd_load),
        .dvsr_o     (dvsr),
        .fixed_o    (fixed_val),
        .neg_q_o    (neg_q),
        .neg_r_o    (neg_r),
        .special_o  (special)
    );

    idiv_core #(.XLEN(XLEN)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (core_load),
        .step_i (core_step),
        .dvd_i  (dvd_load),
        .dvsr_i (dvsr),
        .quo_o  (quo_mag),
        .rem_o  (rem_mag)
    );

    idiv_fix #(.XLEN(XLEN)) u_fix (
        .ctl_i       (ctl_q),
        .use_fixed_i (state_q == ST_PREP),
        .fixed_i     (fixed_val),
        .quo_i       (quo_mag),
        .rem_i       (rem_mag),
        .neg_q_i     (neg_q),
        .neg_r_i     (neg_r),
        .res_o       (fix_res)
    );

endmodule

// File: rtl/idiv_seq_chk.sv
module idiv_seq_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic [1:0]      op_i,
    input logic            word_i,
    input logic            mode64_i,
    input logic [XLEN-1:0] opa_i,
    input logic [XLEN-1:0] opb_i,
    input logic            busy_o,
    input logic            done_o,
    input logic [XLEN-1:0] result_o
);
    localparam int HALF = XLEN / 2;
    localparam int CW   = $clog2(XLEN + 4);

    logic            lat_rem;
    logic            lat_zero;
    logic            lat_narrow;
    logic [XLEN-1:0] lat_a;
    logic [CW-1:0]   busy_cnt;
    logic            nar_in;

    assign nar_in = word_i | ~mode64_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_rem    <= 1'b0;
            lat_zero   <= 1'b0;
            lat_narrow <= 1'b0;
            lat_a      <= '0;
        end else if (start_i && !busy_o) begin
            lat_rem    <= op_i[1];
            lat_narrow <= nar_in;
            lat_zero   <= nar_in ? (opb_i[HALF-1:0] == '0) : (opb_i == '0);
            lat_a      <= nar_in ? {{HALF{opa_i[HALF-1]}}, opa_i[HALF-1:0]} : opa_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt <= '0;
        end else begin
            busy_cnt <= busy_o ? busy_cnt + CW'(1) : '0;
        end
    end

    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (busy_cnt < CW'(XLEN + 2)));                                 // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);                                                    // R9
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && busy_o));                                                   // R9
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result_o) |-> done_o);                                         // R9
    AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);                                       // R10
    AST_DIVZERO_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !lat_rem && lat_zero) |-> (result_o == {XLEN{1'b1}}));       // R3
    AST_REMZERO_DIVIDEND: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && lat_rem && lat_zero) |-> (result_o == lat_a));               // R4
    AST_NARROW_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && lat_narrow) |-> (result_o[XLEN-1:HALF] == {HALF{result_o[HALF-1]}})); // R6

endmodule

bind idiv_seq_unit idiv_seq_chk #(.XLEN(XLEN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .op_i     (op_i),
    .word_i   (word_i),
    .mode64_i (mode64_i),
    .opa_i    (opa_i),
    .opb_i    (opb_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .result_o (result_o)
);

// File: tb/tb_idiv_seq_unit.sv
`timescale 1ns/1ps
module tb_idiv_seq_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  op_i = 2'b00;
    logic        word_i = 1'b0;
    logic        mode64_i = 1'b1;
    logic [63:0] opa_i = '0;
    logic [63:0] opb_i = '0;
    logic        busy_o;
    logic        done_o;
    logic [63:0] result_o;

    idiv_seq_unit dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .op_i     (op_i),
        .word_i   (word_i),
        .mode64_i (mode64_i),
        .opa_i    (opa_i),
        .opb_i    (opb_i),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .result_o (result_o)
    );

    always #4 clk = ~clk;   // 125 MHz

    typedef struct {
        logic [63:0] exp;
        int          lat;
        string       tag;
        int          acc;
    } item_t;

    item_t       sb_q[$];
    int          n_chk = 0;
    int          n_fail = 0;
    int          cyc = 0;
    bit          post_pend = 1'b0;
    logic [63:0] last_res = '0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Specification model
    function automatic logic [63:0] model(input logic [1:0] op, input bit nar,
                                          input logic [63:0] a, input logic [63:0] b);
        logic [31:0]        r32;
        logic [63:0]        r64;
        logic signed [31:0] sa32, sb32;
        logic signed [63:0] sa64, sb64;
        if (nar) begin
            sa32 = a[31:0];
            sb32 = b[31:0];
            case (op)
                2'b00: r32 = (b[31:0] == 0) ? 32'hFFFFFFFF :
                             (a[31:0] == 32'h80000000 && b[31:0] == 32'hFFFFFFFF) ? 32'h80000000 :
                             32'(sa32 / sb32);
                2'b01: r32 = (b[31:0] == 0) ? 32'hFFFFFFFF : a[31:0] / b[31:0];
                2'b10: r32 = (b[31:0] == 0) ? a[31:0] :
                             (a[31:0] == 32'h80000000 && b[31:0] == 32'hFFFFFFFF) ? 32'h0 :
                             32'(sa32 % sb32);
                default: r32 = (b[31:0] == 0) ? a[31:0] : a[31:0] % b[31:0];
            endcase
            return {{32{r32[31]}}, r32};
        end
        sa64 = a;
        sb64 = b;
        case (op)
            2'b00: r64 = (b == 0) ? '1 :
                         (a == 64'h8000000000000000 && b == '1) ? a : 64'(sa64 / sb64);
            2'b01: r64 = (b == 0) ? '1 : a / b;
            2'b10: r64 = (b == 0) ? a :
                         (a == 64'h8000000000000000 && b == '1) ? '0 : 64'(sa64 % sb64);
            default: r64 = (b == 0) ? a : a % b;
        endcase
        return r64;
    endfunction

    task automatic issue(input logic [1:0] op, input bit word, input bit m64,
                         input logic [63:0] a, input logic [63:0] b, input bit poke);
        item_t it;
        bit    nar, zero, ovf, chained;
        nar  = word | !m64;
        zero = nar ? (b[31:0] == 0) : (b == 0);
        ovf  = !op[0] && (nar ? (a[31:0] == 32'h80000000 && b[31:0] == 32'hFFFFFFFF)
                              : (a == 64'h8000000000000000 && b == '1));
        while (busy_o) @(negedge clk);
        chained = done_o;
        it.exp = model(op, nar, a, b);
        it.lat = (zero || ovf) ? 1 : (nar ? 34 : 66);
        it.tag = zero ? (op[1] ? "R4" : "R3") : ovf ? "R5" : poke ? "R8" : nar ? "R6" : "R2";
        it.acc = cyc + 1;
        sb_q.push_back(it);
        start_i  = 1'b1;
        op_i     = op;
        word_i   = word;
        mode64_i = m64;
        opa_i    = a;
        opb_i    = b;
        @(negedge clk);
        start_i = 1'b0;
        opa_i   = ~a;
        opb_i   = b ^ 64'h5;
        if (chained) chk(busy_o == 1'b1, "R10", {63'd0, busy_o}, 64'd1);
        if (poke) begin
            start_i = 1'b1;
            op_i    = ~op;
            opa_i   = 64'h1234;
            opb_i   = 64'd3;
            @(negedge clk);
            start_i = 1'b0;
        end
    endtask

    // Monitor: pops the scoreboard on every done pulse
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_o) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R9", {63'd0, done_o}, 64'd0);
                end else begin
                    item_t it;
                    it = sb_q.pop_front();
                    chk(result_o == it.exp, it.tag, result_o, it.exp);
                    chk((cyc - it.acc) == it.lat, "R7", 64'(cyc - it.acc), 64'(it.lat));
                end
                post_pend = 1'b1;
                last_res  = result_o;
            end else if (post_pend) begin
                chk(!done_o && result_o == last_res, "R9", result_o, last_res);
                post_pend = 1'b0;
            end
        end
    end

    initial begin : watchdog
        wait (cyc >= 150000);
        n_chk++;
        n_fail++;
        $display("FAIL R7: watchdog expired actual=%0d expected<150000", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : stim
        logic [63:0] ra, rb;
        repeat (3) @(negedge clk);
        chk(busy_o == 0, "R1", {63'd0, busy_o}, 64'd0);
        chk(done_o == 0, "R1", {63'd0, done_o}, 64'd0);
        chk(result_o == 0, "R1", result_o, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy_o == 0 && done_o == 0 && result_o == 0, "R1", result_o, 64'd0);

        // R2 full-width basics
        issue(2'b00, 0, 1, 64'd100, 64'd7, 0);
        issue(2'b10, 0, 1, -64'sd100, 64'd7, 0);
        issue(2'b00, 0, 1, -64'sd100, 64'd7, 0);
        issue(2'b01, 0, 1, '1, 64'd3, 0);
        issue(2'b11, 0, 1, 64'hFEDC_BA98_7654_3210, 64'h1_0000_0001, 0);
        // R3 zero divisor quotients
        issue(2'b00, 0, 1, 64'd55, 64'd0, 0);
        issue(2'b01, 1, 1, 64'd55, 64'hFFFF_FFFF_0000_0000, 0);
        // R4 zero divisor remainders
        issue(2'b10, 0, 1, -64'sd9, 64'd0, 0);
        issue(2'b11, 1, 1, 64'h1234_5678_8000_0005, 64'd0, 0);
        // R5 overflow, both widths
        issue(2'b00, 0, 1, 64'h8000_0000_0000_0000, '1, 0);
        issue(2'b10, 0, 1, 64'h8000_0000_0000_0000, '1, 0);
        issue(2'b00, 1, 1, 64'hABCD_0000_8000_0000, 64'h0000_0001_FFFF_FFFF, 0);
        issue(2'b10, 0, 0, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, 0);
        // R6 narrow results sign-extended, upper operand bits ignored
        issue(2'b01, 1, 1, 64'hDEAD_BEEF_FFFF_FFFE, 64'h7777_7777_0000_0001, 0);
        issue(2'b11, 0, 0, 64'h1111_1111_F000_0007, 64'h2222_2222_F000_0000, 0);
        issue(2'b00, 1, 1, 64'h0000_0000_8000_0000, 64'h0000_0000_0000_0001, 0);
        // R8 start while busy
        issue(2'b00, 0, 1, 64'd1000, 64'd9, 1);
        issue(2'b11, 1, 1, 64'd77, 64'd10, 1);
        // Idle gap then a non-chained start
        repeat (5) @(negedge clk);
        issue(2'b10, 0, 1, 64'd17, -64'sd5, 0);

        for (int i = 0; i < 150; i++) begin
            ra = {$urandom, $urandom};
            case ($urandom % 8)
                0: rb = '0;
                1: rb = '1;
                2: rb = 64'($urandom % 16);
                3: begin rb = '1; ra = ($urandom % 2) ? 64'h8000_0000_0000_0000 : 64'h0000_0000_8000_0000; end
                default: rb = {$urandom, $urandom} >> ($urandom % 64);
            endcase
            if (i % 25 == 0) repeat (3) @(negedge clk);
            issue(2'($urandom), 1'($urandom), 1'($urandom), ra, rb, 0);
        end

        while (sb_q.size() != 0 || busy_o) @(negedge clk);
        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule